// File: doc/BRIEF.md
# Keyboard Wake and Processor Clock Gate Controller

This block decides when the processor clock runs. It has three power modes: active, where the processor runs; snooze, where the processor has halted and its clock is stopped until input arrives; and coma, where the machine is off. It watches the eight keyboard row lines, passes the processor clock enable, and raises one interrupt request that asks the processor to scan the keyboard. It tells the keyboard column drivers which idle pattern to apply. In snooze, every column is pulled low so that any key shows up on a row. In coma, only the two top columns are pulled low so that only the top two rows can wake the machine.

A wake from coma is only provisional. The clock starts and a scan is requested, and the machine becomes fully on only when software confirms the key pair by writing the turn-on strobe. If that write does not come within a set number of scan ticks, the block drops back to coma. Outside coma, a scan tick every `TICK_CYCLES` cycles (10 ms by default) also raises the request. Row inputs pass through a two-stage synchronizer before any wake decision is taken.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset the block is in coma: `clk_en_o`=0, `irq_o`=0, `col_mode_o`=2'b10. Column mode encoding: 2'b00 means the processor drives the columns for scanning, 2'b01 means all columns low, 2'b10 means only the top two columns (bits 7 and 6) low.
- R2: In coma, wake starts only when row bits 7 and 6 are both 0 after synchronization. Then `clk_en_o`=1, `irq_o`=1 and `col_mode_o`=2'b00. Either bit low on its own, or any other rows low, leave the block in coma.
- R3: After a coma wake, a `turn_on_wr_i` pulse makes the block fully active, and the clock then stays on past the timeout. Without that pulse, the block returns to coma (`clk_en_o`=0, `irq_o`=0, `col_mode_o`=2'b10) at the `TIMEOUT_TICKS`-th scan tick after the wake.
- R4: Outside coma, a scan tick occurs every `TICK_CYCLES` cycles and sets `irq_o`. Successive request rises, each acknowledged, are exactly `TICK_CYCLES` cycles apart. No tick occurs in coma.
- R5: `irq_o` stays high until `irq_ack_i`. A tick that arrives while a request is pending merges into it, so one acknowledge clears both. A tick in the same cycle as an acknowledge leaves `irq_o` high.
- R6: In active, `halt_i` moves the block to snooze (`clk_en_o`=0, `col_mode_o`=2'b01) only when no request is pending and no tick falls in that cycle. While a request is pending, `halt_i` has no effect.
- R7: In snooze, any row at 0 returns the block to active, with `clk_en_o` and `irq_o` rising in the same cycle.
- R8: A tick that falls due in snooze returns the block to active, with the clock enabled whenever `irq_o` is high.
- R9: In active, a `power_off_wr_i` pulse moves the block to coma at the next edge, clears `irq_o` and stops the clock.
- R10: A row change takes effect on the third rising edge after it is applied (two synchronizer stages, then the state register). After two edges, the outputs are still unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Processor has halted and waits for input |
| rows_i | input | 8 | Keyboard row lines, active low |
| turn_on_wr_i | input | 1 | Software write confirming power-on |
| power_off_wr_i | input | 1 | Software write requesting power-off |
| irq_ack_i | input | 1 | Acknowledge of the scan request |
| clk_en_o | output | 1 | Processor clock enable |
| irq_o | output | 1 | Keyboard scan interrupt request |
| col_mode_o | output | 2 | Idle column drive pattern (encoding in R1) |

## Verification
Two pairs of events can land on the same edge. A periodic tick can meet an interrupt acknowledge, and a tick can meet a halt. The bench locks onto the tick phase by timing one request rise, then raises the acknowledge exactly in the cycle whose closing edge carries the next tick. It judges the result by `irq_o` remaining high afterwards, and by a second, single acknowledge then clearing it. The halt case is judged by `clk_en_o` staying high while a request is pending and falling one edge after the acknowledge takes effect.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    typedef enum logic [1:0] {
        PS_COMA   = 2'd0,
        PS_WAKING = 2'd1,
        PS_ACTIVE = 2'd2,
        PS_SNOOZE = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        COL_SCAN = 2'b00,
        COL_ALL  = 2'b01,
        COL_PAIR = 2'b10
    } col_mode_e;
endpackage

// File: rtl/pwr_row_sync.sv
module pwr_row_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '1;
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
    parameter int PERIOD = 1_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] rows_i,
    output logic         any_low_o,
    output logic         pair_low_o
);
    localparam int HI = W - 1;
    localparam int LO = W - 2;

    assign any_low_o  = ~&rows_i;
    assign pair_low_o = ~rows_i[HI] & ~rows_i[LO];
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_pkg::*;
#(
    parameter int ROW_W         = 8,
    parameter int TICK_CYCLES   = 1_250_000,
    parameter int TIMEOUT_TICKS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic [ROW_W-1:0] rows_i,
    input  logic             turn_on_wr_i,
    input  logic             power_off_wr_i,
    input  logic             irq_ack_i,
    output logic             clk_en_o,
    output logic             irq_o,
    output logic [1:0]       col_mode_o
);
    localparam int WCW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [WCW-1:0] WAIT_LAST = WCW'(TIMEOUT_TICKS - 1);

    typedef struct packed {
        pwr_state_e     state;
        logic           irq;
        logic [WCW-1:0] wait_cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [ROW_W-1:0] rows_s;
    logic             tick;
    logic             any_low;
    logic             pair_low;
    pwr_state_e       state_cur;

    assign state_cur = st_q.state;

    pwr_row_sync #(.W(ROW_W), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rows_i),
        .q_o   (rows_s)
    );

    pwr_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (st_q.state != PS_COMA),
        .tick_o (tick)
    );

    pwr_wake_detect #(.W(ROW_W)) u_detect (
        .rows_i     (rows_s),
        .any_low_o  (any_low),
        .pair_low_o (pair_low)
    );

    always_comb begin
        st_d = st_q;
        // pending request survives unless acknowledged; new events merge in
        if (irq_ack_i) st_d.irq = 1'b0;
        if (tick)      st_d.irq = 1'b1;

        unique case (st_q.state)
            PS_COMA: begin
                st_d.irq = 1'b0;
                if (pair_low) begin
                    st_d.state    = PS_WAKING;
                    st_d.irq      = 1'b1;
                    st_d.wait_cnt = '0;
                end
            end
            PS_WAKING: begin
                if (turn_on_wr_i) begin
                    st_d.state = PS_ACTIVE;
                end else if (tick) begin
                    if (st_q.wait_cnt == WAIT_LAST) begin
                        st_d.state = PS_COMA;
                        st_d.irq   = 1'b0;
                    end else begin
                        st_d.wait_cnt = st_q.wait_cnt + 1'b1;
                    end
                end
            end
            PS_ACTIVE: begin
                if (power_off_wr_i) begin
                    st_d.state = PS_COMA;
                    st_d.irq   = 1'b0;
                end else if (halt_i && !st_q.irq && !tick) begin
                    st_d.state = PS_SNOOZE;
                end
            end
            PS_SNOOZE: begin
                if (any_low || tick) begin
                    st_d.state = PS_ACTIVE;
                    st_d.irq   = 1'b1;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state    <= PS_COMA;
            st_q.irq      <= 1'b0;
            st_q.wait_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_en_o = (st_q.state == PS_ACTIVE) || (st_q.state == PS_WAKING);
    assign irq_o    = st_q.irq;

    always_comb begin
        unique case (st_q.state)
            PS_COMA:   col_mode_o = COL_PAIR;
            PS_SNOOZE: col_mode_o = COL_ALL;
            default:   col_mode_o = COL_SCAN;
        endcase
    end
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk
    import pwr_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt_i,
    input logic             power_off_wr_i,
    input logic             irq_ack_i,
    input logic             clk_en_o,
    input logic             irq_o,
    input logic [1:0]       col_mode_o,
    input logic [ROW_W-1:0] rows_s,
    input logic             tick,
    input pwr_state_e       state_cur
);
    localparam int HI = ROW_W - 1;
    localparam int LO = ROW_W - 2;

    AST_IRQ_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> clk_en_o); // R8

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !irq_ack_i |=> irq_o || !clk_en_o); // R5

    AST_TICK_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !power_off_wr_i |=> irq_o || !clk_en_o); // R4

    AST_NO_TICK_COMA: assert property (@(posedge clk) disable iff (!rst_n)
        state_cur == PS_COMA |-> !tick); // R4

    AST_COMA_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        state_cur == PS_COMA && !rows_s[HI] && !rows_s[LO] |=> clk_en_o && irq_o); // R2

    AST_COMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        state_cur == PS_COMA && (rows_s[HI] || rows_s[LO]) |=> !clk_en_o); // R2

    AST_SNOOZE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        state_cur == PS_SNOOZE && !(&rows_s) |=> clk_en_o && irq_o); // R7

    AST_HALT_SNOOZE: assert property (@(posedge clk) disable iff (!rst_n)
        state_cur == PS_ACTIVE && halt_i && !irq_o && !tick && !power_off_wr_i
        |=> !clk_en_o && col_mode_o == COL_ALL); // R6

    AST_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        state_cur == PS_ACTIVE && power_off_wr_i
        |=> !clk_en_o && !irq_o && col_mode_o == COL_PAIR); // R9
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .halt_i         (halt_i),
    .power_off_wr_i (power_off_wr_i),
    .irq_ack_i      (irq_ack_i),
    .clk_en_o       (clk_en_o),
    .irq_o          (irq_o),
    .col_mode_o     (col_mode_o),
    .rows_s         (rows_s),
    .tick           (tick),
    .state_cur      (state_cur)
);

// File: tb/pwr_wake_ctrl_test.sv
module pwr_wake_ctrl_test;
    localparam int N = 40;
    localparam int T = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_i = 1'b0;
    logic [7:0] rows_i = 8'hFF;
    logic       turn_on_wr_i = 1'b0;
    logic       power_off_wr_i = 1'b0;
    logic       irq_ack_i = 1'b0;
    logic       clk_en_o;
    logic       irq_o;
    logic [1:0] col_mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwr_wake_ctrl #(.ROW_W(8), .TICK_CYCLES(N), .TIMEOUT_TICKS(T)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .halt_i         (halt_i),
        .rows_i         (rows_i),
        .turn_on_wr_i   (turn_on_wr_i),
        .power_off_wr_i (power_off_wr_i),
        .irq_ack_i      (irq_ack_i),
        .clk_en_o       (clk_en_o),
        .irq_o          (irq_o),
        .col_mode_o     (col_mode_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; halt_i = 1'b0; rows_i = 8'hFF;
        turn_on_wr_i = 1'b0; power_off_wr_i = 1'b0; irq_ack_i = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic ack();
        irq_ack_i = 1'b1;
        cyc(1);
        irq_ack_i = 1'b0;
    endtask

    // counts negedges until irq_o is seen high
    task automatic wait_irq(output int n);
        n = 0;
        while (!irq_o && n < 10 * N) begin
            cyc(1);
            n++;
        end
    endtask

    task automatic coma_wake();
        rows_i = 8'h3F;
        cyc(2);
        chk("R10", "clk_en after two edges", clk_en_o, 0);
        cyc(1);
        chk("R2", "clk_en on coma wake", clk_en_o, 1);
        chk("R2", "irq on coma wake", irq_o, 1);
        chk("R2", "col mode on coma wake", col_mode_o, 0);
        rows_i = 8'hFF;
    endtask

    task automatic bring_up();
        do_reset();
        coma_wake();
        turn_on_wr_i = 1'b1;
        irq_ack_i = 1'b1;
        cyc(1);
        turn_on_wr_i = 1'b0;
        irq_ack_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "clk_en", clk_en_o, 0);
        chk("R1", "irq", irq_o, 0);
        chk("R1", "col mode", col_mode_o, 2);
    endtask

    task automatic t_coma_ignore();
        do_reset();
        rows_i = 8'h7F; cyc(4);
        chk("R2", "only row7 low", clk_en_o, 0);
        rows_i = 8'hBF; cyc(4);
        chk("R2", "only row6 low", clk_en_o, 0);
        rows_i = 8'hC0; cyc(3 * N);
        chk("R2", "lower rows low", clk_en_o, 0);
        chk("R4", "no tick in coma", irq_o, 0);
        rows_i = 8'hFF;
    endtask

    task automatic t_timeout();
        do_reset();
        coma_wake();
        ack();
        chk("R5", "ack clears", irq_o, 0);
        cyc(T * N - 3);
        chk("R3", "clock on before timeout", clk_en_o, 1);
        cyc(4);
        chk("R3", "clock off after timeout", clk_en_o, 0);
        chk("R3", "irq cleared after timeout", irq_o, 0);
        chk("R3", "col mode after timeout", col_mode_o, 2);
    endtask

    task automatic t_turn_on();
        bring_up();
        cyc(T * N + 5);
        chk("R3", "clock stays on after turn-on", clk_en_o, 1);
    endtask

    task automatic t_tick_period();
        int n;
        bring_up();
        wait_irq(n);
        chk("R4", "first tick seen", irq_o, 1);
        ack();
        chk("R5", "ack clears", irq_o, 0);
        wait_irq(n);
        chk("R4", "tick interval", n + 1, N);
    endtask

    task automatic t_merge();
        int n;
        bring_up();
        wait_irq(n);
        cyc(N);
        chk("R5", "held without ack over next tick", irq_o, 1);
        ack();
        chk("R5", "single ack clears merged", irq_o, 0);
        cyc(N - 2);
        chk("R5", "idle before coincident tick", irq_o, 0);
        ack();
        chk("R5", "tick wins over same-cycle ack", irq_o, 1);
        ack();
        chk("R5", "cleared afterwards", irq_o, 0);
    endtask

    task automatic t_snooze();
        int n;
        bring_up();
        wait_irq(n);
        halt_i = 1'b1;
        cyc(2);
        chk("R6", "halt ignored while pending", clk_en_o, 1);
        ack();
        chk("R6", "clock on at ack edge", clk_en_o, 1);
        cyc(1);
        chk("R6", "snooze clock off", clk_en_o, 0);
        chk("R6", "snooze col mode", col_mode_o, 1);
        rows_i = 8'hFB;
        cyc(2);
        chk("R10", "snooze wake delayed", clk_en_o, 0);
        cyc(1);
        chk("R7", "snooze wake clock", clk_en_o, 1);
        chk("R7", "snooze wake irq", irq_o, 1);
        rows_i = 8'hFF;
        ack();
        cyc(1);
        chk("R6", "back to snooze", clk_en_o, 0);
        wait_irq(n);
        chk("R8", "tick wakes snooze irq", irq_o, 1);
        chk("R8", "tick wakes snooze clock", clk_en_o, 1);
        halt_i = 1'b0;
    endtask

    task automatic t_power_off();
        bring_up();
        cyc(5);
        power_off_wr_i = 1'b1;
        cyc(1);
        power_off_wr_i = 1'b0;
        chk("R9", "clock off", clk_en_o, 0);
        chk("R9", "irq cleared", irq_o, 0);
        chk("R9", "col mode coma", col_mode_o, 2);
    endtask

    initial begin
        t_reset();
        t_coma_ignore();
        t_timeout();
        t_turn_on();
        t_tick_period();
        t_merge();
        t_snooze();
        t_power_off();
        done = 1'b1;
    end

    initial begin
        int cnt = 0;
        while (!done && cnt < 150000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule